// File: doc/BRIEF.md
# Endpoint Interrupt Mask and Status

This block gathers interrupt requests from eight endpoints of a USB device controller. Each endpoint has a bit in a mask register and a bit in a sticky status register. Endpoint logic raises single-cycle event pulses. A pulse sets its status bit only while that endpoint's mask bit is clear. The mask is applied where a status bit gets set, not on the output. Masking an endpoint therefore stops new requests but leaves a pending one in place.

The processor sees a single interrupt line, which is the OR of all status bits. Software uses a small register bus to program the mask, to read the status, and to clear status bits by writing ones. The mask sits at address 0 and the status at address 1. Both are 32 bits wide, with the endpoint bits in bits 7:0.

Top module: `ep_irq_ctl`

## Requirements
- R1: After reset the mask reads 0x000000FF, the status reads 0, and `irq` is low.
- R2: A write to address 0 stores `wdata[7:0]` as the mask. Mask bit n equal to 1 disables endpoint n and 0 enables it. Bits 31:8 read back as 0, and writes to them are ignored.
- R3: An event pulse on an endpoint whose mask bit is 1 leaves that status bit at 0.
- R4: An event pulse on an endpoint whose mask bit is 0 sets status bit n at the clock edge that samples the pulse. The bit stays set until software clears it.
- R5: Setting a mask bit to 1 does not change a status bit that is already set.
- R6: Writing to address 1 clears every status bit whose `wdata` bit is 1. Bits written as 0 keep their value.
- R7: If a clear of bit n and an enabled event on endpoint n fall in the same cycle, bit n stays set.
- R8: `irq` is high exactly when any status bit is set, whatever the current mask.
- R9: `rdata` shows the register selected while `rd_en` was high, one clock edge later. An address other than 0 or 1 reads 0.
- R10: An event pulse in the same cycle as a mask write is judged against the mask value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | 8 | Per-endpoint single-cycle event pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address (0 = mask, 1 = status) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after `rd_en` |
| irq | output | 1 | Combined interrupt request |

## Verification
The following results land on the same clock edge that samples the stimulus:
- mask writes
- status sets from event pulses
- status clears

Because `irq` is derived combinationally from the status register, it changes after that same edge, and the bench checks it at the following falling edge. Read data is due one edge after `rd_en`. A monitor records each read strobe at the rising edge and compares `rdata` at the next falling edge against the value the driver queued. Every register value is therefore observed only after the edge that produces it.

// File: rtl/ep_irq_ctl.sv
module ep_irq_ctl #(
  parameter int NUM_EP    = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int MASK_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ev_pulse,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  logic [NUM_EP-1:0] mask_q;
  logic [NUM_EP-1:0] stat_q;
  logic [DATA_W-1:0] rd_mux;

  wire sel_mask = (addr == MASK_ADDR[ADDR_W-1:0]);
  wire sel_stat = (addr == STAT_ADDR[ADDR_W-1:0]);
  wire [NUM_EP-1:0] wbits = wdata[NUM_EP-1:0];
  wire unused_wdata_hi = ^wdata[DATA_W-1:NUM_EP];

  wire [NUM_EP-1:0] set_v = ev_pulse & ~mask_q;
  wire [NUM_EP-1:0] clr_v = (wr_en && sel_stat) ? wbits : '0;

  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '1;
    else if (wr_en && sel_mask)
      mask_q <= wbits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      stat_q <= '0;
    else
      stat_q <= (stat_q & ~clr_v) | set_v;
  end

  always_comb begin
    rd_mux = '0;
    if (sel_mask)
      rd_mux[NUM_EP-1:0] = mask_q;
    else if (sel_stat)
      rd_mux[NUM_EP-1:0] = stat_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
  end

  assign irq = |stat_q;

endmodule

module ep_irq_chk #(
  parameter int NUM_EP    = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int MASK_ADDR = 0,
  parameter int STAT_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ev,
  input logic [NUM_EP-1:0] mask,
  input logic [NUM_EP-1:0] status,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata
);

  wire is_mask = (addr == MASK_ADDR[ADDR_W-1:0]);
  wire is_stat = (addr == STAT_ADDR[ADDR_W-1:0]);
  wire [NUM_EP-1:0] clr_req = (wr_en && is_stat) ? wdata[NUM_EP-1:0] : '0;

  p_masked_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & $past(mask)) == '0));

  p_enabled_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(ev) & ~$past(mask)) & ~status) == '0));

  p_clear_only_by_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(status) & ~status & ~$past(clr_req)) == '0));

  p_read_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_mask) |=> (rdata[NUM_EP-1:0] == $past(mask)));

  p_read_other_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_mask && !is_stat) |=> (rdata == '0));

endmodule

bind ep_irq_ctl ep_irq_chk #(
  .NUM_EP(NUM_EP), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .MASK_ADDR(MASK_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev_pulse), .mask(mask_q), .status(stat_q),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
);

// File: tb/tb_ep_irq_ctl.sv
module tb_ep_irq_ctl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ev_pulse = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  logic        done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_irq_ctl dut (
    .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= rd_en;

  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) check("R9 unexpected read", rdata, 32'h0);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic step(input logic [7:0] ev, input logic we, input logic [3:0] a, input logic [31:0] d);
    ev_pulse = ev; wr_en = we; addr = a; wdata = d;
    @(negedge clk);
    ev_pulse = '0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'd0, 32'h0000_00FF, "R1 mask after reset");
    rd(4'd1, 32'h0, "R1 status after reset");
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    // R3 masked events ignored
    step(8'hFF, 1'b0, 4'd0, 32'h0);
    rd(4'd1, 32'h0, "R3 masked events");
    check("R3 irq stays low", {31'b0, irq}, 32'h0);
    // R2 reserved bits ignored
    step(8'h00, 1'b1, 4'd0, 32'hABCD_EF5A);
    rd(4'd0, 32'h0000_005A, "R2 mask readback");
    // R10 event alongside mask write uses old mask (bit1 was 1)
    step(8'h02, 1'b1, 4'd0, 32'h0);
    rd(4'd1, 32'h0, "R10 old mask applies");
    rd(4'd0, 32'h0, "R2 mask cleared");
    // R4 enabled events set sticky bits
    step(8'h81, 1'b0, 4'd0, 32'h0);
    check("R8 irq after set", {31'b0, irq}, 32'h1);
    repeat (3) @(negedge clk);
    rd(4'd1, 32'h81, "R4 sticky status");
    // R5 masking keeps pending bits
    step(8'h00, 1'b1, 4'd0, 32'hFF);
    step(8'h7E, 1'b0, 4'd0, 32'h0);
    rd(4'd1, 32'h81, "R5 pending kept after mask");
    check("R8 irq with masked pending", {31'b0, irq}, 32'h1);
    // R6 write-one-to-clear
    step(8'h00, 1'b1, 4'd1, 32'h01);
    rd(4'd1, 32'h80, "R6 clear bit0");
    step(8'h00, 1'b1, 4'd1, 32'h00);
    rd(4'd1, 32'h80, "R6 zero write no effect");
    step(8'h00, 1'b1, 4'd1, 32'h80);
    rd(4'd1, 32'h0, "R6 clear bit7");
    check("R8 irq low when empty", {31'b0, irq}, 32'h0);
    // R7 event beats clear
    step(8'h00, 1'b1, 4'd0, 32'h00);
    step(8'h04, 1'b0, 4'd0, 32'h0);
    step(8'h04, 1'b1, 4'd1, 32'h04);
    rd(4'd1, 32'h04, "R7 event wins over clear");
    step(8'h00, 1'b1, 4'd1, 32'h04);
    rd(4'd1, 32'h0, "R7 later clear");
    // R9 unknown address
    rd(4'd5, 32'h0, "R9 unmapped address");
    @(negedge clk);
    if (exp_q.size() != 0) check("R9 reads outstanding", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        check("watchdog expired", 32'h1, 32'h0);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule